// File: doc/BRIEF.md
# Shadow RAM Segment Attribute Decoder

This block sits between the configuration bytes that control shadow RAM and the memory access path. It sorts each access into the upper ROM area (0xC0000 to 0xFFFFF) and reports where a read is fetched from and where a write is sent. The area from 0xC0000 to 0xEFFFF is cut into twelve 16 KB segments. Each segment is set up by three things: its own enable bit, a mode bit and a ROM bit shared by each 64 KB group, and one global copy bit. The 64 KB BIOS segment at 0xF0000 has its own rules, and the 4 KB at its bottom can be write-enabled separately.

Routing is combinational from the four configuration bytes and the access address, so a memory controller can steer the cycle at once. Three summary flags (high shadow in use, BIOS shadowed, BIOS writable) are registered and follow any change to the configuration one clock later. The DRAM access itself and the external bus cycle are handled elsewhere.

Top module: `shadow_seg_decoder`

## Requirements
- R1: An address outside 0xC0000–0xFFFFF drives `decoded` low, `rd_src` to 0 (none) and `wr_dst` to 0 (none). Inside the area `decoded` is high. The read codes are 1 = internal DRAM, 2 = external bus, 3 = any-external. The write codes are 1 = internal DRAM, 2 = external bus, 3 = disabled.
- R2: Segment i (0–11) covers 0xC0000 + i·0x4000 for 16 KB. Segments 0–3 take their enable from `cfg_seg_lo` bit i+4. Segments 4–11 take it from `cfg_seg_hi` bit i−4.
- R3: The mode bit of segment i is `cfg_grp` bit i/4. Its ROM bit is `cfg_grp` bit i/4+4. The segment is active when both its enable bit and its ROM bit are set.
- R4: An active segment reads from internal DRAM (1). If its mode bit is clear, writes are disabled (3).
- R5: An active segment with its mode bit set writes to internal DRAM (1) when `cfg_grp` bit 3 is set, and to the external bus (2) when that bit is clear.
- R6: An inactive segment has writes disabled (3). It reads any-external (3) at or above 0xE0000 and from the external bus (2) below 0xE0000.
- R7: When `cfg_grp` bit 7 is set, all of 0xF0000–0xFFFFF reads any-external (3) and writes internal DRAM (1).
- R8: When `cfg_grp` bit 7 is clear, 0xF0000–0xFFFFF reads internal DRAM (1). Writes to 0xF0000–0xF0FFF go to internal DRAM (1) if `cfg_bios` bit 7 is set, and are disabled (3) otherwise. Writes to 0xF1000–0xFFFFF are always disabled (3).
- R9: One clock after the configuration is sampled, the flags are set as follows. `high_shadow` is set if any active segment lies at or above 0xD0000 (segments 4–11). `bios_shadowed` is set if `cfg_grp` bit 7 is clear or segment 8–11 is active. `bios_writable` is set if `cfg_grp` bit 7 is set, `cfg_bios` bit 7 is set, or an active segment 8–11 has its mode bit set. The address has no effect on the flags.
- R10: `wr_reject` is high exactly when `acc_wr` is high, the address is decoded and `wr_dst` is disabled (3).
- R11: While `rst_n` is low at a clock edge, all three flags are cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_grp | input | 8 | Group modes [2:0], copy [3], group ROM [6:4], BIOS-external [7] |
| cfg_seg_hi | input | 8 | Enables for segments 4–11 (bit i−4) |
| cfg_seg_lo | input | 8 | Enables for segments 0–3 in bits [7:4]; bits [3:0] unused here |
| cfg_bios | input | 8 | Bit 7: first 4 KB of the BIOS segment writable |
| acc_addr | input | ADDR_W (24) | Access address |
| acc_wr | input | 1 | Write strobe |
| decoded | output | 1 | Address lies in 0xC0000–0xFFFFF |
| rd_src | output | 2 | Read source code |
| wr_dst | output | 2 | Write target code |
| wr_reject | output | 1 | Write strobe aimed at a disabled target |
| high_shadow | output | 1 | Shadow active at or above 0xD0000 |
| bios_shadowed | output | 1 | BIOS area served from internal DRAM |
| bios_writable | output | 1 | Some BIOS area accepts writes |

## Verification
Assertions check a set of rules on every cycle. An undecoded address always carries zero codes. A bus read always comes with writes disabled. Any-external reads only happen in the top 128 KB. The BIOS tail is read-only when bit 7 is clear. A reject needs a write strobe. The flags obey the ROM-bit and reset rules one cycle on. Other properties can only be shown by the bench's directed scenarios: the exact mapping of each of the twelve segments to its enable, mode and ROM bits, the choice the copy bit makes, the 4 KB boundary inside the BIOS segment, and the exact flag values for given configurations.

// File: rtl/shadow_pkg.sv
// Package: shared routing codes and address-layout constants for the
// shadow segment decoder. Assumes a 1 MB real-mode address map.
package shadow_pkg;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_DRAM   = 2'd1,
        RD_BUS    = 2'd2,
        RD_ANYEXT = 2'd3
    } rd_src_e;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_DRAM = 2'd1,
        WR_BUS  = 2'd2,
        WR_OFF  = 2'd3
    } wr_dst_e;

    localparam int SEG_SHIFT  = 14;  // 16 KB segments
    localparam int PAGE_SHIFT = 12;  // 4 KB granularity for BIOS low page
    localparam int AREA_SHIFT = 18;  // 256 KB upper area

endpackage

// File: rtl/shadow_seg_attr.sv
// Module: per-segment attribute decode for one 16 KB shadow segment.
// Combines the segment enable, group ROM and mode bits and the global
// copy bit into read/write routing. UPPER selects the inactive read
// source for segments at or above 0xE0000. Purely combinational.
module shadow_seg_attr
    import shadow_pkg::*;
#(
    parameter bit UPPER = 1'b0
) (
    input  logic    seg_en,
    input  logic    grp_rom,
    input  logic    grp_mode,
    input  logic    copy_en,
    output logic    active,
    output rd_src_e rd,
    output wr_dst_e wr
);

    // Purpose: route reads and writes from the segment's control bits.
    always_comb begin
        active = seg_en & grp_rom;
        if (active) begin
            rd = RD_DRAM;
            if (!grp_mode)
                wr = WR_OFF;
            else if (copy_en)
                wr = WR_DRAM;
            else
                wr = WR_BUS;
        end else begin
            rd = UPPER ? RD_ANYEXT : RD_BUS;
            wr = WR_OFF;
        end
    end

endmodule

// File: rtl/shadow_bios_attr.sv
// Module: routing for the 64 KB BIOS segment at 0xF0000.
// Assumes the caller has already found the address in that segment.
// in_low_page is high for 0xF0000-0xF0FFF. Purely combinational.
module shadow_bios_attr
    import shadow_pkg::*;
(
    input  logic    rom_external,
    input  logic    low_page_we,
    input  logic    in_low_page,
    output rd_src_e rd,
    output wr_dst_e wr
);

    // Purpose: pick BIOS routing from the external flag and low-page enable.
    always_comb begin
        if (rom_external) begin
            rd = RD_ANYEXT;
            wr = WR_DRAM;
        end else begin
            rd = RD_DRAM;
            wr = (in_low_page && low_page_we) ? WR_DRAM : WR_OFF;
        end
    end

endmodule

// File: rtl/shadow_flags.sv
// Module: registered summary flags for the shadow configuration.
// Samples segment activity and the BIOS controls every clock; the flags
// therefore follow a configuration change one cycle later. Synchronous
// active-low reset clears all flags.
module shadow_flags #(
    parameter int NUM_SEG  = 12,
    parameter int SEG_GRP  = 4,
    parameter int HIGH_SEG = 4,
    parameter int BIOS_SEG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEG-1:0] seg_active,
    input  logic [NUM_SEG-1:0] seg_mode,
    input  logic               rom_external,
    input  logic               low_page_we,
    input  logic [2:0]         grp_rom,
    output logic               high_shadow,
    output logic               bios_shadowed,
    output logic               bios_writable
);

    logic any_high;
    logic any_bios;
    logic any_bios_wr;

    // Purpose: reduce segment activity into the three summary terms.
    always_comb begin
        any_high    = 1'b0;
        any_bios    = 1'b0;
        any_bios_wr = 1'b0;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (k >= HIGH_SEG)
                any_high = any_high | seg_active[k];
            if (k >= BIOS_SEG) begin
                any_bios    = any_bios | seg_active[k];
                any_bios_wr = any_bios_wr | (seg_active[k] & seg_mode[k]);
            end
        end
    end

    // Purpose: register the flags with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_shadow   <= 1'b0;
            bios_shadowed <= 1'b0;
            bios_writable <= 1'b0;
        end else begin
            high_shadow   <= any_high;
            bios_shadowed <= any_bios | ~rom_external;
            bios_writable <= any_bios_wr | rom_external | low_page_we;
        end
    end

    // With no group ROM bit above 0xD0000 set, the high flag must drop.
    p_high_needs_rom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_rom[2:1] == 2'b00) |=> !high_shadow);

    // BIOS served internally whenever it is not external.
    p_bios_internal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_external |=> bios_shadowed);

    // Reset clears every flag.
    p_flags_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!high_shadow && !bios_shadowed && !bios_writable));

endmodule

// File: rtl/shadow_seg_decoder.sv
// Module: top of the shadow RAM segment attribute decoder.
// Decodes an access address against 0xC0000-0xFFFFF, selects the
// attribute of the addressed 16 KB segment or of the BIOS segment, and
// exposes registered summary flags. Assumes configuration bytes are
// held stable by their owner; routing is combinational.
module shadow_seg_decoder
    import shadow_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NUM_SEG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_grp,
    input  logic [7:0]        cfg_seg_hi,
    input  logic [7:0]        cfg_seg_lo,
    input  logic [7:0]        cfg_bios,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    output logic              decoded,
    output logic [1:0]        rd_src,
    output logic [1:0]        wr_dst,
    output logic              wr_reject,
    output logic              high_shadow,
    output logic              bios_shadowed,
    output logic              bios_writable
);

    localparam int SEG_PER_GRP = 4;
    localparam int LO_SEGS     = 4;
    localparam int UPPER_FIRST = 8;
    localparam int TAG_W       = ADDR_W - AREA_SHIFT;
    localparam int IDX_W       = AREA_SHIFT - SEG_SHIFT;
    localparam int PG_W        = SEG_SHIFT + 2 - PAGE_SHIFT;
    localparam logic [TAG_W-1:0] AREA_TAG = TAG_W'(3);
    localparam logic [IDX_W-1:0] BIOS_IDX = IDX_W'(NUM_SEG);

    logic [NUM_SEG-1:0] seg_en;
    logic [NUM_SEG-1:0] seg_active;
    logic [NUM_SEG-1:0] seg_mode;
    rd_src_e            seg_rd [NUM_SEG];
    wr_dst_e            seg_wr [NUM_SEG];

    logic               area_hit;
    logic [IDX_W-1:0]   seg_idx;
    logic               in_bios;
    logic               in_low_page;
    rd_src_e            bios_rd;
    wr_dst_e            bios_wr;
    rd_src_e            rd_sel;
    wr_dst_e            wr_sel;

    genvar g;
    generate
        for (g = 0; g < NUM_SEG; g++) begin : gen_seg
            if (g < LO_SEGS) begin : gen_lo
                assign seg_en[g] = cfg_seg_lo[g+4];
            end else begin : gen_hi
                assign seg_en[g] = cfg_seg_hi[g-LO_SEGS];
            end
            assign seg_mode[g] = cfg_grp[g/SEG_PER_GRP];

            shadow_seg_attr #(
                .UPPER (g >= UPPER_FIRST)
            ) i_seg (
                .seg_en   (seg_en[g]),
                .grp_rom  (cfg_grp[g/SEG_PER_GRP + 4]),
                .grp_mode (seg_mode[g]),
                .copy_en  (cfg_grp[3]),
                .active   (seg_active[g]),
                .rd       (seg_rd[g]),
                .wr       (seg_wr[g])
            );
        end
    endgenerate

    // Purpose: locate the access within the upper area.
    always_comb begin
        area_hit    = (acc_addr[ADDR_W-1:AREA_SHIFT] == AREA_TAG);
        seg_idx     = acc_addr[AREA_SHIFT-1:SEG_SHIFT];
        in_bios     = (seg_idx >= BIOS_IDX);
        in_low_page = (acc_addr[SEG_SHIFT+1:PAGE_SHIFT] == '0);
    end

    shadow_bios_attr i_bios (
        .rom_external (cfg_grp[7]),
        .low_page_we  (cfg_bios[7]),
        .in_low_page  (in_low_page),
        .rd           (bios_rd),
        .wr           (bios_wr)
    );

    // Purpose: select the routing of the addressed segment.
    always_comb begin
        rd_sel = RD_NONE;
        wr_sel = WR_NONE;
        if (area_hit) begin
            if (in_bios) begin
                rd_sel = bios_rd;
                wr_sel = bios_wr;
            end else begin
                for (int k = 0; k < NUM_SEG; k++) begin
                    if (seg_idx == IDX_W'(k)) begin
                        rd_sel = seg_rd[k];
                        wr_sel = seg_wr[k];
                    end
                end
            end
        end
    end

    // Purpose: drive the routing ports and the write reject strobe.
    always_comb begin
        decoded   = area_hit;
        rd_src    = rd_sel;
        wr_dst    = wr_sel;
        wr_reject = acc_wr & area_hit & (wr_sel == WR_OFF);
    end

    shadow_flags #(
        .NUM_SEG  (NUM_SEG),
        .SEG_GRP  (SEG_PER_GRP),
        .HIGH_SEG (LO_SEGS),
        .BIOS_SEG (UPPER_FIRST)
    ) i_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .seg_active    (seg_active),
        .seg_mode      (seg_mode),
        .rom_external  (cfg_grp[7]),
        .low_page_we   (cfg_bios[7]),
        .grp_rom       (cfg_grp[6:4]),
        .high_shadow   (high_shadow),
        .bios_shadowed (bios_shadowed),
        .bios_writable (bios_writable)
    );

    // Undecoded accesses carry no routing.
    p_undecoded_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !decoded |-> (rd_src == 2'd0 && wr_dst == 2'd0));

    // Any-external reads only in 0xE0000-0xFFFFF.
    p_anyext_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (decoded && rd_src == 2'd3) |-> (acc_addr[17:16] >= 2'b10));

    // A read from the external bus means the segment is not shadowed.
    p_bus_read_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == 2'd2) |-> (wr_dst == 2'd3));

    // BIOS tail above the low 4 KB is read-only while BIOS is internal.
    p_bios_tail_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (decoded && acc_addr[17:16] == 2'b11 && acc_addr[15:12] != 4'h0
         && !cfg_grp[7]) |-> (wr_dst == 2'd3));

    // Reject requires a write strobe on a decoded address.
    p_reject_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> (acc_wr && decoded && wr_dst == 2'd3));

endmodule

// File: tb/test_shadow_seg_decoder.sv
// Directed bench for the shadow segment decoder.
module test_shadow_seg_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_grp, cfg_seg_hi, cfg_seg_lo, cfg_bios;
    logic [23:0] acc_addr;
    logic        acc_wr;
    logic        decoded, wr_reject;
    logic [1:0]  rd_src, wr_dst;
    logic        high_shadow, bios_shadowed, bios_writable;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    shadow_seg_decoder i_shadow_seg_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_grp(cfg_grp), .cfg_seg_hi(cfg_seg_hi),
        .cfg_seg_lo(cfg_seg_lo), .cfg_bios(cfg_bios),
        .acc_addr(acc_addr), .acc_wr(acc_wr),
        .decoded(decoded), .rd_src(rd_src), .wr_dst(wr_dst),
        .wr_reject(wr_reject), .high_shadow(high_shadow),
        .bios_shadowed(bios_shadowed), .bios_writable(bios_writable)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of one segment from R2-R6: returns {rd, wr}.
    function automatic logic [3:0] seg_model(input int i);
        logic en, rom, md;
        en  = (i < 4) ? cfg_seg_lo[i+4] : cfg_seg_hi[i-4];
        md  = cfg_grp[i/4];
        rom = cfg_grp[i/4+4];
        if (en && rom)
            return {2'd1, (!md) ? 2'd3 : (cfg_grp[3] ? 2'd1 : 2'd2)};
        return {(i >= 8) ? 2'd3 : 2'd2, 2'd3};
    endfunction

    task automatic access(input logic [23:0] a, input logic w);
        @(negedge clk);
        acc_addr = a;
        acc_wr   = w;
        #1;
    endtask

    task automatic sweep_segments(input string tag);
        for (int i = 0; i < 12; i++) begin
            logic [3:0] e;
            e = seg_model(i);
            access(24'hC0000 + 24'(i) * 24'h4000 + 24'h1FF0, 1'b0);
            chk({tag, " R2 rd"}, rd_src, e[3:2]);
            chk({tag, " R2 wr"}, wr_dst, e[1:0]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cfg_grp = 8'h00; cfg_seg_hi = 8'h00; cfg_seg_lo = 8'h00; cfg_bios = 8'h00;
        acc_addr = 24'h0; acc_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 high", high_shadow, 0);
        chk("R11 bios_sh", bios_shadowed, 0);
        chk("R11 bios_wr", bios_writable, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_outside();
        access(24'h0BFFFF, 1'b1);
        chk("R1 dec", decoded, 0); chk("R1 rd", rd_src, 0); chk("R1 wr", wr_dst, 0);
        chk("R1 rej", wr_reject, 0);
        access(24'h1C0000, 1'b0);
        chk("R1 dec hi", decoded, 0); chk("R1 rd hi", rd_src, 0);
        access(24'h0C0000, 1'b0);
        chk("R1 dec in", decoded, 1);
    endtask

    task automatic t_inactive();
        @(negedge clk);
        cfg_grp = 8'h8F; cfg_seg_hi = 8'hFF; cfg_seg_lo = 8'hF0;
        access(24'h0C4000, 1'b0);
        chk("R6 rd C", rd_src, 2); chk("R6 wr C", wr_dst, 3);
        access(24'h0DFFFF, 1'b0);
        chk("R6 rd D", rd_src, 2);
        access(24'h0E0000, 1'b0);
        chk("R6 rd E", rd_src, 3); chk("R6 wr E", wr_dst, 3);
    endtask

    task automatic t_active_patterns();
        @(negedge clk);
        cfg_grp = 8'h70; cfg_seg_hi = 8'hFF; cfg_seg_lo = 8'hF0;
        sweep_segments("R4 all ro");
        access(24'h0D8000, 1'b0);
        chk("R4 rd", rd_src, 1); chk("R4 wr", wr_dst, 3);
        @(negedge clk);
        cfg_grp = 8'h7F;
        access(24'h0C0000, 1'b0);
        chk("R5 copy wr", wr_dst, 1);
        @(negedge clk);
        cfg_grp = 8'h77;
        access(24'h0EC000, 1'b0);
        chk("R5 bus wr", wr_dst, 2);
        @(negedge clk);
        cfg_grp = 8'h53; cfg_seg_hi = 8'hA5; cfg_seg_lo = 8'h60;
        sweep_segments("R3 mixed");
        @(negedge clk);
        cfg_grp = 8'h3A; cfg_seg_hi = 8'h5A; cfg_seg_lo = 8'h90;
        sweep_segments("R3 mixed2");
    endtask

    task automatic t_bios();
        @(negedge clk);
        cfg_grp = 8'h80; cfg_bios = 8'h00;
        access(24'h0F0000, 1'b0);
        chk("R7 rd", rd_src, 3); chk("R7 wr", wr_dst, 1);
        access(24'h0FFFFF, 1'b0);
        chk("R7 wr top", wr_dst, 1);
        @(negedge clk);
        cfg_grp = 8'h00;
        access(24'h0F0FFF, 1'b0);
        chk("R8 rd", rd_src, 1); chk("R8 low off", wr_dst, 3);
        @(negedge clk);
        cfg_bios = 8'h80;
        access(24'h0F0FFF, 1'b0);
        chk("R8 low on", wr_dst, 1);
        access(24'h0F1000, 1'b0);
        chk("R8 tail", wr_dst, 3);
        @(negedge clk);
        cfg_bios = 8'h7F;
        access(24'h0F0000, 1'b0);
        chk("R8 bit7 only", wr_dst, 3);
    endtask

    task automatic t_reject();
        @(negedge clk);
        cfg_grp = 8'h00; cfg_bios = 8'h00;
        access(24'h0F2000, 1'b1);
        chk("R10 rej", wr_reject, 1);
        access(24'h0F2000, 1'b0);
        chk("R10 no strobe", wr_reject, 0);
        @(negedge clk);
        cfg_grp = 8'h80;
        access(24'h0F2000, 1'b1);
        chk("R10 writable", wr_reject, 0);
    endtask

    task automatic flag_case(input string tag, input logic [7:0] g,
                             input logic [7:0] hi, input logic [7:0] lo,
                             input logic [7:0] b, input int eh,
                             input int es, input int ew);
        @(negedge clk);
        cfg_grp = g; cfg_seg_hi = hi; cfg_seg_lo = lo; cfg_bios = b;
        acc_addr = 24'h000000;
        @(negedge clk);
        chk({tag, " R9 high"}, high_shadow, eh);
        chk({tag, " R9 bios_sh"}, bios_shadowed, es);
        chk({tag, " R9 bios_wr"}, bios_writable, ew);
    endtask

    task automatic t_flags();
        flag_case("none",  8'h80, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        flag_case("lo",    8'h90, 8'h00, 8'hF0, 8'h00, 0, 0, 1);
        flag_case("D",     8'hA0, 8'h01, 8'h00, 8'h00, 1, 0, 1);
        flag_case("E ro",  8'hC0, 8'h10, 8'h00, 8'h00, 1, 1, 1);
        flag_case("int",   8'h00, 8'h00, 8'h00, 8'h00, 0, 1, 0);
        flag_case("int lw",8'h00, 8'h00, 8'h00, 8'h80, 0, 1, 1);
        flag_case("E rw",  8'h44, 8'h80, 8'h00, 8'h00, 1, 1, 1);
        flag_case("E ro2", 8'h40, 8'h80, 8'h00, 8'h00, 1, 1, 0);
        flag_case("noen",  8'h60, 8'h00, 8'h0F, 8'h00, 0, 1, 0);
        // Address has no effect on flags.
        @(negedge clk); acc_addr = 24'h0E4000;
        @(negedge clk);
        chk("R9 addr ind", high_shadow, 0);
        // Flags lag configuration by one clock.
        cfg_grp = 8'hA0; cfg_seg_hi = 8'h01;
        #1 chk("R9 lag before", high_shadow, 0);
        @(negedge clk);
        chk("R9 lag after", high_shadow, 1);
    endtask

    initial begin
        t_reset();
        t_outside();
        t_inactive();
        t_active_patterns();
        t_bios();
        t_reject();
        t_flags();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule